// File: doc/BRIEF.md
# Correlator Channel Start and Code-Slew Sequencer

This block governs when one correlator channel starts running and how its code phase is shifted. A channel-enable bit, written by software, acts as an active-low channel reset. While it is low, the code generator is held in reset and the accumulator is held. The slew value can be loaded at any time. When the bit is set, the channel starts. Channels that are enabled in the same write therefore start in step, with the same code phase.

A slew value does not act at the moment it is written. It is marked pending and waits for a dump strobe. At the first dump strobe that finds the slew counter idle, the pending value is loaded into a down-counter. Each code-clock enable that then arrives is withheld from the code generator and decrements the counter, until the counter is empty. For as long as the counter is non-zero, the accumulate-and-dump stage is held in reset. The first dump after the channel is enabled carries no useful correlation, so the block flags that dump as void.

Top module: `chan_slew_seq`

## Requirements
- R1: After the asynchronous reset `rst_ni`, the slew value is 0 and nothing is pending. A dump strobe after the channel is enabled therefore starts no slew (`slew_busy_o` stays 0).
- R2: While `chan_en_i` is 0, the following hold: `code_rst_o`=1, `acc_hold_o`=1, `code_tick_o`=0 and `dump_void_o`=0. A dump strobe in this state loads nothing.
- R3: In any cycle where `chan_en_i` is 1 and no slew is running, the outputs are `code_rst_o`=0 and `acc_hold_o`=0, and `code_tick_o` follows `code_tick_i` in the same cycle.
- R4: `dump_void_o` is 1 in the cycle of the first `dump_i` after `chan_en_i` rises. It is 0 for every later dump until the channel is disabled again.
- R5: A written slew value N is not applied until a dump strobe. The first N `code_tick_i` pulses after that dump are suppressed from `code_tick_o`. `slew_busy_o` is 1 from the cycle after the dump until the cycle after the Nth suppressed pulse.
- R6: `acc_hold_o` is 1 in every cycle where `slew_busy_o` is 1.
- R7: A pending slew value of 0 is consumed by a dump, and no code ticks are suppressed.
- R8: A slew value written while a slew is running stays pending. A dump that arrives during a running slew does not change the running count. The queued value is applied at the first dump that finds the counter idle.
- R9: A write in the same cycle as a dump that consumes a request leaves the new value pending. The dump loads the value held before that write.
- R10: Setting `chan_en_i` to 0 during a slew aborts the slew: `slew_busy_o` is 0 from the next cycle. After the channel is enabled again, the next dump is void.
- R11: A pending request survives periods in which `chan_en_i` is 0. It is cleared only when a dump consumes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_en_i | input | 1 | Channel enable; 0 holds the channel in reset |
| slew_wr_i | input | 1 | Write strobe for the slew value |
| slew_val_i | input | SLEW_W | Slew amount in code-clock ticks |
| code_tick_i | input | 1 | Code-clock enable pulse from the code NCO |
| dump_i | input | 1 | Dump strobe, one cycle per code epoch |
| code_tick_o | output | 1 | Gated code-clock enable to the code generator |
| code_rst_o | output | 1 | Code generator reset |
| acc_hold_o | output | 1 | Accumulate-and-dump hold (reset) |
| dump_void_o | output | 1 | Marks the current dump's data as don't-care |
| slew_busy_o | output | 1 | High while code ticks are being withheld |

## Verification
The embedded properties rely on the following conditions:
- `dump_i`, `code_tick_i` and `slew_wr_i` are single-cycle strobes, sampled synchronously to `clk_i`.
- `chan_en_i` changes only between clock edges.
- A load reaches the counter only while it is idle.

The stimulus changes every input just after a falling edge and holds it for one full cycle, so each strobe spans exactly one rising edge. Dumps are spaced so that the idle-counter rule is tested both ways: once with a dump during a running slew, and once with a dump after the slew has finished.

// File: rtl/chan_slew_pkg.sv
package chan_slew_pkg;
  localparam int unsigned DEF_SLEW_W = 11;

  typedef enum logic [1:0] {
    CH_HELD  = 2'd0,
    CH_ARMED = 2'd1,
    CH_LIVE  = 2'd2
  } ch_state_e;
endpackage

// File: rtl/slew_req_reg.sv
module slew_req_reg #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] val_i,
  input  logic         consume_i,
  output logic [W-1:0] slew_val_o,
  output logic         pending_o
);
  logic [W-1:0] val_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_i) val_q <= val_i;
      // a write wins over a same-cycle consume
      if (wr_i)           pend_q <= 1'b1;
      else if (consume_i) pend_q <= 1'b0;
    end
  end

  assign slew_val_o = val_q;
  assign pending_o  = pend_q;

  AST_PEND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i && !wr_i |=> !pending_o); // R5
  AST_PEND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pending_o); // R9
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o && !consume_i |=> pending_o); // R11
endmodule

// File: rtl/slew_down_cnt.sv
module slew_down_cnt #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         busy_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i)                   cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (cnt_q != '0 && tick_i)    cnt_q <= cnt_q - W'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign tick_o = tick_i & run_i & ~busy_o;

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && run_i |=> cnt_q == $past(load_val_i)); // R5
  AST_DEC_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !load_i && busy_o && tick_i |=> cnt_q == $past(cnt_q) - W'(1)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !load_i && !tick_i |=> $stable(cnt_q)); // R8
  AST_LOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o); // R8
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !busy_o); // R10
endmodule

// File: rtl/chan_start_ctrl.sv
module chan_start_ctrl
  import chan_slew_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic dump_i,
  input  logic busy_i,
  output logic code_rst_o,
  output logic acc_hold_o,
  output logic dump_void_o
);
  ch_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!run_i)      state_d = CH_HELD;
    else if (dump_i) state_d = CH_LIVE;
    else if (state_q == CH_HELD) state_d = CH_ARMED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CH_HELD;
    else         state_q <= state_d;
  end

  assign code_rst_o  = ~run_i;
  assign acc_hold_o  = ~run_i | busy_i;
  // dump in the release cycle also counts as the first one
  assign dump_void_o = run_i & dump_i & (state_q != CH_LIVE);

  AST_VOID_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_void_o |=> !dump_void_o); // R4
  AST_VOID_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_void_o |=> state_q == CH_LIVE || !$past(run_i)); // R4
  AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> state_q == CH_HELD); // R10
endmodule

// File: rtl/chan_slew_seq.sv
module chan_slew_seq
  import chan_slew_pkg::*;
#(
  parameter int unsigned SLEW_W = DEF_SLEW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_en_i,
  input  logic              slew_wr_i,
  input  logic [SLEW_W-1:0] slew_val_i,
  input  logic              code_tick_i,
  input  logic              dump_i,
  output logic              code_tick_o,
  output logic              code_rst_o,
  output logic              acc_hold_o,
  output logic              dump_void_o,
  output logic              slew_busy_o
);
  logic [SLEW_W-1:0] slew_val;
  logic              pending;
  logic              busy;
  logic              consume;

  // load only into an idle counter; busy dumps leave the request queued
  assign consume = dump_i & chan_en_i & pending & ~busy;

  slew_req_reg #(.W(SLEW_W)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (slew_wr_i),
    .val_i      (slew_val_i),
    .consume_i  (consume),
    .slew_val_o (slew_val),
    .pending_o  (pending)
  );

  slew_down_cnt #(.W(SLEW_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (chan_en_i),
    .load_i     (consume),
    .load_val_i (slew_val),
    .tick_i     (code_tick_i),
    .busy_o     (busy),
    .tick_o     (code_tick_o)
  );

  chan_start_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (chan_en_i),
    .dump_i      (dump_i),
    .busy_i      (busy),
    .code_rst_o  (code_rst_o),
    .acc_hold_o  (acc_hold_o),
    .dump_void_o (dump_void_o)
  );

  assign slew_busy_o = busy;

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slew_busy_o |-> acc_hold_o); // R6
  AST_GATE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slew_busy_o |-> !code_tick_o); // R5
  AST_HELD_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |-> code_rst_o && acc_hold_o && !code_tick_o && !dump_void_o); // R2
  AST_BUSY_NEEDS_DUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slew_busy_o) |-> $past(dump_i)); // R5
endmodule

// File: tb/chan_slew_seq_test.sv
`timescale 1ns/1ps
module chan_slew_seq_test;
  localparam int unsigned W = 11;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en = 1'b0;
  logic         wr = 1'b0;
  logic [W-1:0] val = '0;
  logic         tick = 1'b0;
  logic         dump = 1'b0;
  logic         tick_o, crst_o, hold_o, void_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  logic s_tick, s_rst, s_hold, s_void, s_busy;

  always #2.5 clk = ~clk;

  chan_slew_seq #(.SLEW_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .chan_en_i(en), .slew_wr_i(wr),
    .slew_val_i(val), .code_tick_i(tick), .dump_i(dump),
    .code_tick_o(tick_o), .code_rst_o(crst_o), .acc_hold_o(hold_o),
    .dump_void_o(void_o), .slew_busy_o(busy_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b @%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive after negedge, sample outputs, then let posedge pass
  task automatic cyc(input logic t, input logic d, input logic w, input logic [W-1:0] v);
    @(negedge clk);
    tick = t; dump = d; wr = w; val = v;
    #1;
    s_tick = tick_o; s_rst = crst_o; s_hold = hold_o; s_void = void_o; s_busy = busy_o;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0, '0);
  endtask

  // apply n ticks, return how many got through
  task automatic ticks(input int n, output int passed);
    passed = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b0, '0);
      if (s_tick) passed++;
    end
  endtask

  task automatic t_reset();
    int p;
    en = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, '0);
    chk("R2 code_rst held", s_rst, 1'b1);
    chk("R2 hold held", s_hold, 1'b1);
    chk("R2 tick gated", s_tick, 1'b0);
    chk("R1 busy reset", s_busy, 1'b0);
    en = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R4 void on release dump", s_void, 1'b1);
    idle();
    chk("R1 no slew after reset", s_busy, 1'b0);
    ticks(3, p);
    chk("R3 ticks pass", p == 3, 1'b1);
    chk("R3 hold low", s_hold, 1'b0);
    chk("R3 code_rst low", s_rst, 1'b0);
  endtask

  task automatic t_held_and_first();
    int p;
    en = 1'b0;
    idle();
    cyc(1'b0, 1'b0, 1'b1, W'(2));
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R2 no void while held", s_void, 1'b0);
    idle();
    chk("R2 dump held loads nothing", s_busy, 1'b0);
    en = 1'b1;
    ticks(2, p);
    chk("R5 deferred until dump", p == 2, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R4 first dump void", s_void, 1'b1);
    chk("R11 pending kept over held", s_busy, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, '0);
    chk("R5 busy after dump", s_busy, 1'b1);
    chk("R6 hold while busy", s_hold, 1'b1);
    chk("R5 first tick suppressed", s_tick, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, '0);
    chk("R5 second tick suppressed", s_tick, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, '0);
    chk("R5 busy drops after N", s_busy, 1'b0);
    chk("R5 tick after slew", s_tick, 1'b1);
    chk("R6 hold released", s_hold, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R4 later dump valid", s_void, 1'b0);
    idle();
    chk("R5 consumed request", s_busy, 1'b0);
  endtask

  task automatic t_zero();
    cyc(1'b0, 1'b0, 1'b1, W'(0));
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, 1'b0, '0);
    chk("R7 zero slew no busy", s_busy, 1'b0);
    chk("R7 zero slew tick passes", s_tick, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, W'(1));
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, 1'b0, '0);
    chk("R7 zero consumed, next pending applies", s_tick, 1'b0);
    idle();
  endtask

  task automatic t_queue();
    int p;
    cyc(1'b0, 1'b0, 1'b1, W'(4));
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, 1'b1, W'(2));   // queued write, 1 tick used
    cyc(1'b0, 1'b1, 1'b0, '0);      // dump while busy
    ticks(4, p);
    chk("R8 busy dump keeps count", p == 1, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, '0);
    ticks(3, p);
    chk("R8 queued value applied", p == 1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, W'(1));
    cyc(1'b0, 1'b1, 1'b1, W'(3));   // consume 1, write 3 same cycle
    ticks(2, p);
    chk("R9 dump loads old value", p == 1, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, '0);
    ticks(4, p);
    chk("R9 new value stays pending", p == 1, 1'b1);
  endtask

  task automatic t_abort();
    int p;
    cyc(1'b0, 1'b0, 1'b1, W'(5));
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, 1'b0, '0);
    chk("R10 slew running", s_busy, 1'b1);
    en = 1'b0;
    idle();
    chk("R2 code_rst on drop", s_rst, 1'b1);
    idle();
    chk("R10 busy cleared", s_busy, 1'b0);
    en = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R10 void after re-release", s_void, 1'b1);
    ticks(2, p);
    chk("R10 aborted slew not resumed", p == 2, 1'b1);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_held_and_first();
    t_zero();
    t_queue();
    t_abort();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule